// File: doc/BRIEF.md
# Rolling-Shutter Exposure Sequencer

This block orders the readouts of a rolling-shutter image sensor and drives the shutter (or strobe) output around them. A separate readout engine performs each frame readout. The sequencer asks it to start with a one-cycle `rd_start` pulse and can cancel a running readout with `rd_abort`, which also sends the engine's line pointer back to line 1. The engine reports the end of each readout with a one-cycle `rd_done`. `frame_valid` is high for the whole of every readout whose data goes downstream. All other readouts are dummy readouts that only clear the pixels. `shutter_out` marks the exposure gap between readouts, and its polarity can be set.

A 3-bit mode field selects one of four sequences. Free-run mode loops through forwarded readouts, with an optional timed shutter gap between them. Triggered mode runs a dummy readout, then a shutter gap, then a forwarded readout. Triggered mode without full reset goes straight from the trigger to the shutter gap and the forwarded readout. In pulse-width mode, the length of the shutter gap is the high time of the incoming trigger pulse.

While a triggered mode waits for a trigger, the block keeps issuing dummy readouts so that dark current does not build up. The trigger comes from one of two lines. It is synchronised, optionally inverted so that the falling edge is the active one, and filtered so that pulses shorter than 1 µs are dropped. The shutter time is counted in 10 µs steps, and the tick is derived from the system clock by a prescaler.

Top module: `exposure_sequencer`

## Requirements
- R1: While `rst_n` is low, and until the first request, `frame_valid` is 0, `rd_start` is 0 and `shutter_out` equals `shut_pol`. The first readout requested after reset is a dummy readout (`frame_valid` low).
- R2: In free-run mode (`mode_sel` = 3'b000) with `shutter_time` = 0, forwarded readouts run back to back. The next `rd_start` with `frame_valid` high comes in the cycle after `rd_done`, and the shutter is never active.
- R3: In free-run mode with `shutter_time` = N > 0, the shutter is active for exactly N × STEP_US × CLK_PER_US cycles between consecutive forwarded readouts. The next forwarded readout starts in the cycle the shutter goes inactive.
- R4: In triggered mode (3'b001), a trigger accepted during an idle dummy readout pulses `rd_abort`. In the same cycle it starts a dummy readout with `frame_valid` low. After that readout's `rd_done`, the shutter is active for N steps, and then a forwarded readout starts.
- R5: In triggered mode without full reset (3'b010), an accepted trigger pulses `rd_abort` with no dummy readout. The shutter gap of N steps follows at once, and then the forwarded readout. With N = 0 the forwarded readout starts directly, with no shutter activity.
- R6: In pulse-width mode (3'b011), the shutter is active for exactly as many cycles as the filtered trigger pulse is high. The forwarded readout starts in the cycle the shutter goes inactive.
- R7: In every mode other than free-run, the block keeps requesting dummy readouts (`frame_valid` low) back to back while it waits for a trigger.
- R8: A trigger is accepted only during an idle dummy readout of a triggered mode. A trigger during the dummy pre-readout, the shutter gap or the forwarded readout, or in free-run mode, causes no `rd_abort` and no extra readout.
- R9: A trigger pulse that lasts fewer than MIN_PULSE_US × CLK_PER_US cycles is ignored.
- R10: `trig_src` = 0 selects `trig_cl` and `trig_src` = 1 selects `trig_ttl`. Activity on the line that is not selected has no effect.
- R11: `trig_fall` = 0 makes the rising edge active. `trig_fall` = 1 makes the falling edge active, and the pulse then counts as high while the line is low.
- R12: `shutter_out` is the shutter-active level XOR `shut_pol`. With `shut_pol` = 1 the output idles high and goes low during the shutter gap.
- R13: Reserved mode values (3'b100 to 3'b111) accept no trigger. They produce no `rd_abort` and no forwarded readout, and dummy readouts continue.
- R14: `frame_valid` rises only together with `rd_start`, and once high it stays high until `rd_done`. `frame_valid` and the shutter-active level are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_cl | input | 1 | Trigger line from the camera-link control pair |
| trig_ttl | input | 1 | Trigger line from the TTL connector |
| mode_sel | input | 3 | Sequence mode: 000 free-run, 001 triggered, 010 triggered without full reset, 011 pulse width, others reserved |
| trig_src | input | 1 | Trigger line select: 0 `trig_cl`, 1 `trig_ttl` |
| trig_fall | input | 1 | Active trigger edge: 0 rising, 1 falling |
| shut_pol | input | 1 | Shutter output polarity: 1 inverts |
| shutter_time | input | TIME_W | Shutter gap length in STEP_US steps |
| rd_done | input | 1 | One-cycle pulse from the readout engine at the end of a readout |
| rd_start | output | 1 | One-cycle request to start a readout at line 1 |
| rd_abort | output | 1 | One-cycle request to stop the current readout and reset the line pointer |
| frame_valid | output | 1 | High for the whole of a forwarded readout |
| shutter_out | output | 1 | Shutter or strobe drive |

## Verification
The bound checker watches, on every cycle, the framing rules that hold in every mode. `frame_valid` opens only with a request and closes only on `rd_done`, and it never overlaps the shutter gap. The shutter gap always hands over to a forwarded readout. Reserved and free-run modes never abort, a triggered-mode abort always comes with a dummy start, and free-run with zero shutter time restarts at once. The scenarios must show what depends on the order of events and on durations. These are the exact shutter lengths in steps or in pulse cycles, whether a dummy pre-readout came before the forwarded frame, and the rejection of short pulses, wrong-edge activity, activity on the unselected line and triggers that arrive while a frame is being captured.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_PRE,
        ST_SHUT,
        ST_FWD
    } seq_state_e;

    localparam logic [2:0] MODE_FREE    = 3'b000;
    localparam logic [2:0] MODE_TRIG    = 3'b001;
    localparam logic [2:0] MODE_TRIG_NR = 3'b010;
    localparam logic [2:0] MODE_PULSE   = 3'b011;

endpackage

// File: rtl/trig_conditioner.sv
module trig_conditioner #(
    parameter int FILT_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_a,
    input  logic line_b,
    input  logic src_b,
    input  logic invert,
    output logic lvl,
    output logic evt
);
    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          lvl;
        logic          evt;
    } cond_t;

    cond_t q, d;
    logic  raw;

    assign raw = (src_b ? line_b : line_a) ^ invert;

    always_comb begin
        d     = q;
        d.s1  = raw;
        d.s2  = q.s1;
        d.evt = 1'b0;
        if (q.s2 != q.lvl) begin
            if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                d.lvl = q.s2;
                d.evt = q.s2;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl = q.lvl;
    assign evt = q.evt;
endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int TICK_CYC = 1250,
    parameter int TIME_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic              expire
);
    localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYC - 1);

    typedef struct packed {
        logic [PW-1:0]     presc;
        logic [TIME_W-1:0] rem;
        logic              run;
    } tmr_t;

    tmr_t q, d;
    logic tick;

    assign tick   = q.run && (q.presc == PRE_LAST);
    assign expire = tick && (q.rem == TIME_W'(1));

    always_comb begin
        d = q;
        if (load) begin
            d.presc = '0;
            d.rem   = load_val;
            d.run   = (load_val != '0);
        end else if (q.run) begin
            if (tick) begin
                d.presc = '0;
                d.rem   = q.rem - 1'b1;
                if (q.rem == TIME_W'(1)) d.run = 1'b0;
            end else begin
                d.presc = q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic [TIME_W-1:0] shut_time,
    input  logic              trig_evt,
    input  logic              trig_lvl,
    input  logic              rd_done,
    input  logic              tmr_expire,
    output logic              tmr_load,
    output logic              rd_start,
    output logic              rd_abort,
    output logic              frame_valid,
    output logic              shut_act
);
    typedef struct packed {
        seq_state_e state;
        logic       by_pulse;
        logic       start;
        logic       abort;
    } fsm_t;

    fsm_t q, d;
    logic timed;
    logic trig_mode;

    assign timed     = (shut_time != '0);
    assign trig_mode = (mode == MODE_TRIG) || (mode == MODE_TRIG_NR) || (mode == MODE_PULSE);

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.abort  = 1'b0;
        tmr_load = 1'b0;
        unique case (q.state)
            ST_BOOT: begin
                d.state = ST_IDLE;
                d.start = 1'b1;
            end
            ST_IDLE: begin
                if (trig_evt && trig_mode) begin
                    d.abort = 1'b1;
                    if (mode == MODE_TRIG) begin
                        d.state = ST_PRE;
                        d.start = 1'b1;
                    end else if (mode == MODE_PULSE) begin
                        d.state    = ST_SHUT;
                        d.by_pulse = 1'b1;
                    end else if (timed) begin
                        d.state    = ST_SHUT;
                        d.by_pulse = 1'b0;
                        tmr_load   = 1'b1;
                    end else begin
                        d.state = ST_FWD;
                        d.start = 1'b1;
                    end
                end else if (rd_done) begin
                    if (mode == MODE_FREE && timed) begin
                        d.state    = ST_SHUT;
                        d.by_pulse = 1'b0;
                        tmr_load   = 1'b1;
                    end else begin
                        d.state = (mode == MODE_FREE) ? ST_FWD : ST_IDLE;
                        d.start = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (rd_done) begin
                    if (timed) begin
                        d.state    = ST_SHUT;
                        d.by_pulse = 1'b0;
                        tmr_load   = 1'b1;
                    end else begin
                        d.state = ST_FWD;
                        d.start = 1'b1;
                    end
                end
            end
            ST_SHUT: begin
                if (q.by_pulse ? !trig_lvl : tmr_expire) begin
                    d.state = ST_FWD;
                    d.start = 1'b1;
                end
            end
            ST_FWD: begin
                if (rd_done) begin
                    if (mode == MODE_FREE && timed) begin
                        d.state    = ST_SHUT;
                        d.by_pulse = 1'b0;
                        tmr_load   = 1'b1;
                    end else begin
                        d.state = (mode == MODE_FREE) ? ST_FWD : ST_IDLE;
                        d.start = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state    <= ST_BOOT;
            q.by_pulse <= 1'b0;
            q.start    <= 1'b0;
            q.abort    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_start    = q.start;
    assign rd_abort    = q.abort;
    assign frame_valid = (q.state == ST_FWD);
    assign shut_act    = (q.state == ST_SHUT);
endmodule

// File: rtl/exposure_sequencer.sv
module exposure_sequencer #(
    parameter int CLK_PER_US   = 125,
    parameter int STEP_US      = 10,
    parameter int MIN_PULSE_US = 1,
    parameter int TIME_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_cl,
    input  logic              trig_ttl,
    input  logic [2:0]        mode_sel,
    input  logic              trig_src,
    input  logic              trig_fall,
    input  logic              shut_pol,
    input  logic [TIME_W-1:0] shutter_time,
    input  logic              rd_done,
    output logic              rd_start,
    output logic              rd_abort,
    output logic              frame_valid,
    output logic              shutter_out
);
    localparam int TICK_CYC = CLK_PER_US * STEP_US;
    localparam int FILT_CYC = CLK_PER_US * MIN_PULSE_US;

    logic trig_lvl, trig_evt, tmr_load, tmr_expire, shut_act;

    trig_conditioner #(.FILT_CYC(FILT_CYC)) i_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_a (trig_cl),
        .line_b (trig_ttl),
        .src_b  (trig_src),
        .invert (trig_fall),
        .lvl    (trig_lvl),
        .evt    (trig_evt)
    );

    step_timer #(.TICK_CYC(TICK_CYC), .TIME_W(TIME_W)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (shutter_time),
        .expire   (tmr_expire)
    );

    seq_fsm #(.TIME_W(TIME_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_sel),
        .shut_time   (shutter_time),
        .trig_evt    (trig_evt),
        .trig_lvl    (trig_lvl),
        .rd_done     (rd_done),
        .tmr_expire  (tmr_expire),
        .tmr_load    (tmr_load),
        .rd_start    (rd_start),
        .rd_abort    (rd_abort),
        .frame_valid (frame_valid),
        .shut_act    (shut_act)
    );

    assign shutter_out = shut_act ^ shut_pol;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_sel,
    input logic [TIME_W-1:0] shutter_time,
    input logic              shut_pol,
    input logic              rd_done,
    input logic              rd_start,
    input logic              rd_abort,
    input logic              frame_valid,
    input logic              shutter_out
);
    logic shut_on;
    assign shut_on = shutter_out ^ shut_pol;

    // R14
    fv_opens_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> rd_start);

    // R14
    fv_holds_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !rd_done) |=> frame_valid);

    // R14
    fv_shutter_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && shut_on));

    // R3
    shutter_hands_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shut_on) |-> (rd_start && frame_valid));

    // R2
    free_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && rd_done && mode_sel == 3'b000 && shutter_time == '0)
        |=> (rd_start && frame_valid));

    // R4
    trig_abort_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_abort && $past(mode_sel) == 3'b001) |-> (rd_start && !frame_valid));

    // R13
    no_abort_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[2] && $past(mode_sel[2])) |-> !rd_abort);

    // R8
    no_abort_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b000 && $past(mode_sel) == 3'b000) |-> !rd_abort);
endmodule

bind exposure_sequencer seq_checker #(.TIME_W(TIME_W)) i_seq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .shutter_time (shutter_time),
    .shut_pol     (shut_pol),
    .rd_done      (rd_done),
    .rd_start     (rd_start),
    .rd_abort     (rd_abort),
    .frame_valid  (frame_valid),
    .shutter_out  (shutter_out)
);

// File: tb/test_exposure_sequencer.sv
`timescale 1ns/1ps
module test_exposure_sequencer;
    localparam int CPU    = 4;
    localparam int TICK   = CPU * 10;
    localparam int RD_LEN = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_cl = 1'b0, trig_ttl = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic trig_src = 1'b0, trig_fall = 1'b0, shut_pol = 1'b0;
    logic [15:0] shutter_time = 16'd0;
    logic rd_done = 1'b0;
    logic rd_start, rd_abort, frame_valid, shutter_out;

    always #4 clk = ~clk;

    exposure_sequencer #(.CLK_PER_US(CPU), .STEP_US(10), .MIN_PULSE_US(1), .TIME_W(16)) i_exposure_sequencer (
        .clk(clk), .rst_n(rst_n), .trig_cl(trig_cl), .trig_ttl(trig_ttl),
        .mode_sel(mode_sel), .trig_src(trig_src), .trig_fall(trig_fall),
        .shut_pol(shut_pol), .shutter_time(shutter_time), .rd_done(rd_done),
        .rd_start(rd_start), .rd_abort(rd_abort), .frame_valid(frame_valid),
        .shutter_out(shutter_out)
    );

    int checks = 0, errors = 0;
    int fwd_seen = 0, dummy_seen = 0, abort_seen = 0;
    int shut_len = 0;
    bit dummy_flag = 0;
    logic [16:0] exp_q[$];
    bit done_flag = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input bit dummy, input int slen);
        exp_q.push_back({dummy, 16'(slen)});
    endtask

    // readout engine model
    initial begin
        bit busy = 0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            rd_done = 1'b0;
            if (rd_abort) busy = 0;
            if (rd_start) begin
                busy = 1;
                cnt = RD_LEN;
            end else if (busy) begin
                cnt--;
                if (cnt == 0) begin
                    rd_done = 1'b1;
                    busy = 0;
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bit shut;
                shut = shutter_out ^ shut_pol;
                if (shut) shut_len++;
                if (frame_valid && shut) check(0, "R14 fv and shutter overlap", 1, 0);
                if (rd_abort) begin
                    abort_seen++;
                    dummy_flag = rd_start && !frame_valid;
                end else if (rd_start && !frame_valid) dummy_flag = 1;
                if (rd_start && !frame_valid) dummy_seen++;
                if (rd_start && frame_valid) begin
                    fwd_seen++;
                    if (exp_q.size() == 0) begin
                        check(0, "R8 unexpected forwarded readout", fwd_seen, 0);
                    end else begin
                        logic [16:0] e;
                        e = exp_q.pop_front();
                        check(dummy_flag == e[16], "R4/R5 dummy pre-readout", int'(dummy_flag), int'(e[16]));
                        check(shut_len == int'(e[15:0]), "R3/R4/R5/R6 shutter length", shut_len, int'(e[15:0]));
                    end
                    shut_len = 0;
                    dummy_flag = 0;
                end
            end
        end
    end

    task automatic pulse_cl(input int n);
        @(negedge clk); trig_cl = 1'b1;
        repeat (n) @(negedge clk);
        trig_cl = 1'b0;
    endtask

    task automatic pulse_ttl(input int n, input bit low_active);
        @(negedge clk); trig_ttl = !low_active;
        repeat (n) @(negedge clk);
        trig_ttl = low_active;
    endtask

    task automatic wait_fv_low();
        @(negedge clk);
        while (frame_valid) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int a0, f0, d0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(frame_valid == 1'b0, "R1 fv in reset", int'(frame_valid), 0);
        check(rd_start == 1'b0, "R1 start in reset", int'(rd_start), 0);
        check(shutter_out == shut_pol, "R1 shutter idle in reset", int'(shutter_out), int'(shut_pol));

        // R2 free-run, zero shutter time
        push_exp(1, 0); push_exp(0, 0); push_exp(0, 0);
        rst_n = 1'b1;
        wait (dummy_seen >= 1 || fwd_seen >= 1);
        check(fwd_seen == 0, "R1 first readout is dummy", fwd_seen, 0);
        wait (fwd_seen >= 3);

        // R3 free-run with a shutter gap of 2 steps
        @(negedge clk); shutter_time = 16'd2;
        push_exp(0, 2 * TICK); push_exp(0, 2 * TICK);
        wait (fwd_seen >= 5);
        @(negedge clk); mode_sel = 3'b001;
        check(abort_seen == 0, "R8 no abort in free-run", abort_seen, 0);
        wait_fv_low();

        // R7 idle dummy readouts
        d0 = dummy_seen;
        repeat (100) @(negedge clk);
        check(dummy_seen >= d0 + 3, "R7 idle dummy readouts", dummy_seen - d0, 3);

        // R4 triggered mode
        a0 = abort_seen;
        push_exp(1, 2 * TICK);
        pulse_cl(8);
        wait (fwd_seen >= 6);
        check(abort_seen == a0 + 1, "R4 one abort", abort_seen, a0 + 1);

        // R8 trigger during forwarded readout
        pulse_cl(8);
        wait_fv_low();
        repeat (30) @(negedge clk);
        check(abort_seen == a0 + 1, "R8 trigger in forwarded readout ignored", abort_seen, a0 + 1);

        // R8 trigger during shutter gap
        push_exp(1, 2 * TICK);
        pulse_cl(8);
        wait ((shutter_out ^ shut_pol) == 1'b1);
        pulse_cl(8);
        wait (fwd_seen >= 7);
        check(abort_seen == a0 + 2, "R8 trigger in shutter ignored", abort_seen, a0 + 2);
        wait_fv_low();

        // R9 short pulse
        a0 = abort_seen; f0 = fwd_seen;
        pulse_cl(2);
        repeat (60) @(negedge clk);
        check(abort_seen == a0, "R9 short pulse ignored", abort_seen, a0);
        check(fwd_seen == f0, "R9 no frame after short pulse", fwd_seen, f0);

        // R10 source select
        @(negedge clk); trig_src = 1'b1;
        pulse_cl(8);
        repeat (60) @(negedge clk);
        check(abort_seen == a0, "R10 unselected line ignored", abort_seen, a0);
        push_exp(1, 2 * TICK);
        pulse_ttl(8, 1'b0);
        wait (fwd_seen >= f0 + 1);
        check(abort_seen == a0 + 1, "R10 selected line accepted", abort_seen, a0 + 1);
        wait_fv_low();

        // R11 falling edge
        @(negedge clk); trig_ttl = 1'b1; trig_fall = 1'b1;
        repeat (20) @(negedge clk);
        check(abort_seen == a0 + 1, "R11 idle-high line not a trigger", abort_seen, a0 + 1);
        push_exp(1, 2 * TICK);
        pulse_ttl(8, 1'b1);
        wait (fwd_seen >= f0 + 2);
        check(abort_seen == a0 + 2, "R11 falling edge accepted", abort_seen, a0 + 2);
        wait_fv_low();
        @(negedge clk); trig_ttl = 1'b0; trig_fall = 1'b0; trig_src = 1'b0;
        repeat (20) @(negedge clk);

        // R5 no full reset
        @(negedge clk); mode_sel = 3'b010; shutter_time = 16'd1;
        f0 = fwd_seen;
        push_exp(0, TICK);
        pulse_cl(8);
        wait (fwd_seen >= f0 + 1);
        wait_fv_low();
        @(negedge clk); shutter_time = 16'd0;
        push_exp(0, 0);
        pulse_cl(8);
        wait (fwd_seen >= f0 + 2);
        wait_fv_low();

        // R6 and R12 pulse-width mode with inverted shutter
        @(negedge clk); mode_sel = 3'b011; shut_pol = 1'b1;
        repeat (5) @(negedge clk);
        check(shutter_out == 1'b1, "R12 inverted idle level", int'(shutter_out), 1);
        push_exp(0, 30);
        pulse_cl(30);
        wait (fwd_seen >= f0 + 3);
        wait_fv_low();

        // R13 reserved mode
        @(negedge clk); mode_sel = 3'b101; shut_pol = 1'b0;
        repeat (30) @(negedge clk);
        a0 = abort_seen; f0 = fwd_seen; d0 = dummy_seen;
        pulse_cl(8);
        repeat (100) @(negedge clk);
        check(abort_seen == a0, "R13 no abort in reserved", abort_seen, a0);
        check(fwd_seen == f0, "R13 no frame in reserved", fwd_seen, f0);
        check(dummy_seen > d0, "R13 dummies continue", dummy_seen - d0, 1);

        check(exp_q.size() == 0, "R14 all expected frames seen", exp_q.size(), 0);
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule